// File: doc/BRIEF.md
# Nibble SEC/DED Encoder and Corrector

This block guards a 4-bit data nibble with an 8-bit codeword. The codeword holds three even-parity check bits whose coverage groups overlap, plus one whole-word parity bit. The encoder half is purely combinational. It turns a nibble into the codeword that is stored or sent.

The corrector half accepts a received codeword together with a valid strobe. It recomputes the three check bits and compares them with the received ones to form a 3-bit syndrome. It also checks the parity of the whole word.

The syndrome is decoded one-hot into per-bit flip strobes. Every codeword position has its own strobe, including the check bits and the whole-word parity bit. Each strobe drives a two-input XOR on its bit.

The whole-word parity then splits the outcomes into four cases:
- no error,
- a single error that has been repaired,
- a lone error in the whole-word parity bit,
- a double error that cannot be repaired.

The result is registered one cycle after the input strobe. Outputs are the repaired codeword, the repaired nibble and three mutually exclusive status flags.

Top module: `secded_corrector`

## Requirements
- R1: Codeword layout: bits 3..0 carry the data d3..d0. Bit 6 = d3^d2^d1, bit 5 = d3^d2^d0 and bit 4 = d3^d1^d0, so each check group including its check bit has even weight.
- R2: Bit 7 of the encoded word makes the parity of all eight bits even.
- R3: A received word with zero syndrome and even overall parity gives outClean=1, outCorrected=0 and outUncorr=0. The word is passed unchanged.
- R4: A single flipped data bit (bits 3..0) is inverted back. outData is the original nibble and outCorrected=1.
- R5: A single flipped check bit (bits 6..4) is inverted back, and outData is unchanged. outCorrected=1.
- R6: A flip of bit 7 alone leaves the syndrome zero but makes the overall parity odd. Bit 7 is restored, the data is reported as valid and outCorrected=1.
- R7: A nonzero syndrome with even overall parity sets outUncorr=1 only. The received word and nibble are passed out untouched.
- R8: outValid is high exactly in the cycle after a cycle with inValid high. While inValid is low, outWord, outData and the flags hold their last values.
- R9: Reset (active low, asynchronous) clears outValid, outWord, outData and all three flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encData | input | 4 | Nibble to encode |
| encWord | output | 8 | Codeword for encData (combinational) |
| inValid | input | 1 | inWord holds a word to check this cycle |
| inWord | input | 8 | Received codeword |
| outValid | output | 1 | Registered results are fresh |
| outWord | output | 8 | Repaired codeword (raw word on a double error) |
| outData | output | 4 | Repaired nibble |
| outClean | output | 1 | No error was found |
| outCorrected | output | 1 | One bit was inverted |
| outUncorr | output | 1 | Double error, word not repaired |

## Verification
The checks that run every cycle cover four properties:
- the flags are one-hot whenever outValid is high;
- outValid tracks inValid with one cycle of delay, and the outputs hold while no word arrives;
- every repaired word is itself a valid codeword;
- on an uncorrectable result the received word passes through unaltered.

They also check that at most one flip strobe fires, and that no strobe fires on a double error. Only the bench scenarios can show that the right bit is chosen and the right nibble recovered. To do this they inject every single-bit position and several double patterns into all sixteen nibbles. They also show that the encoder layout matches the stated groups, and that reset clears the outputs.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W   = 4;
  localparam int CHK_W    = 3;
  localparam int BODY_W   = DATA_W + CHK_W;
  localparam int WORD_W   = BODY_W + 1;
  localparam int SYN_LINES = 1 << CHK_W;
  localparam int OVR_POS  = WORD_W - 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [WORD_W-1:0] flip;
    logic              clean;
    logic              fixed;
    logic              uncorr;
  } fixCtl_t;

  // check bits: [2] over d3,d2,d1  [1] over d3,d2,d0  [0] over d3,d1,d0
  function automatic logic [CHK_W-1:0] calcChecks(input logic [DATA_W-1:0] d);
    calcChecks = {d[3] ^ d[2] ^ d[1], d[3] ^ d[2] ^ d[0], d[3] ^ d[1] ^ d[0]};
  endfunction

  function automatic logic [WORD_W-1:0] buildWord(input logic [DATA_W-1:0] d);
    logic [BODY_W-1:0] body;
    body = {calcChecks(d), d};
    buildWord = {^body, body};
  endfunction
endpackage

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   encData,
  input  logic [WORD_W-1:0]   rxWord,
  input  fixCtl_t             ctl,
  output logic [WORD_W-1:0]   encWord,
  output logic [CHK_W-1:0]    syndrome,
  output logic                ovrMismatch,
  output logic [WORD_W-1:0]   fixedWord
);
  assign encWord     = buildWord(encData);
  assign syndrome    = calcChecks(rxWord[DATA_W-1:0]) ^ rxWord[BODY_W-1:DATA_W];
  assign ovrMismatch = ^rxWord;

  // one two-input XOR per codeword position
  for (genvar i = 0; i < WORD_W; i++) begin : g_fix
    assign fixedWord[i] = rxWord[i] ^ ctl.flip[i];
  end

  // R2
  enc_even_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (^encWord) == 1'b0);

  // R1
  enc_data_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    encWord[DATA_W-1:0] == encData);
endmodule

// File: rtl/secded_control.sv
module secded_control
  import secded_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CHK_W-1:0] syndrome,
  input  logic             ovrMismatch,
  output fixCtl_t          ctl
);
  logic [SYN_LINES-1:0] line;

  // 3-to-8 syndrome decoder
  for (genvar g = 0; g < SYN_LINES; g++) begin : g_line
    assign line[g] = (syndrome == CHK_W'(g));
  end

  // data positions: strobe taken from the line equal to that bit's column
  for (genvar i = 0; i < DATA_W; i++) begin : g_dataFlip
    localparam logic [CHK_W-1:0] COL = calcChecks(DATA_W'(1) << i);
    assign ctl.flip[i] = line[COL] & ovrMismatch;
  end

  // check positions: a lone check bit has a unit column
  for (genvar j = 0; j < CHK_W; j++) begin : g_chkFlip
    localparam int COLC = 1 << j;
    assign ctl.flip[DATA_W+j] = line[COLC] & ovrMismatch;
  end

  // zero syndrome with odd parity: whole-word bit is the culprit
  assign ctl.flip[OVR_POS] = line[0] & ovrMismatch;

  assign ctl.clean  = line[0] & ~ovrMismatch;
  assign ctl.fixed  = ovrMismatch;
  assign ctl.uncorr = ~line[0] & ~ovrMismatch;

  // R4
  flip_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.flip));

  // R7
  no_flip_on_double_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.uncorr |-> (ctl.flip == '0));
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  output logic [WORD_W-1:0] encWord,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic [DATA_W-1:0] outData,
  output logic              outClean,
  output logic              outCorrected,
  output logic              outUncorr
);
  fixCtl_t           ctl;
  logic [CHK_W-1:0]  syndrome;
  logic              ovrMismatch;
  logic [WORD_W-1:0] fixedWord;

  secded_datapath u_datapath (
    .clk(clk), .rstN(rstN), .encData(encData), .rxWord(inWord), .ctl(ctl),
    .encWord(encWord), .syndrome(syndrome), .ovrMismatch(ovrMismatch),
    .fixedWord(fixedWord)
  );

  secded_control u_control (
    .clk(clk), .rstN(rstN), .syndrome(syndrome), .ovrMismatch(ovrMismatch),
    .ctl(ctl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outWord      <= '0;
      outClean     <= 1'b0;
      outCorrected <= 1'b0;
      outUncorr    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outWord      <= fixedWord;
        outClean     <= ctl.clean;
        outCorrected <= ctl.fixed;
        outUncorr    <= ctl.uncorr;
      end
    end
  end

  assign outData = outWord[DATA_W-1:0];

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outWord) && $stable(outUncorr)));

  // R3
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot({outClean, outCorrected, outUncorr}));

  // R4
  repaired_is_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outUncorr) |->
      ((^outWord) == 1'b0 && calcChecks(outWord[DATA_W-1:0]) == outWord[BODY_W-1:DATA_W]));

  // R7
  double_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUncorr) |-> (outWord == $past(inWord)));
endmodule

// File: tb/secded_corrector_tb.sv
module secded_corrector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_MASK = 12;
  // {error mask, class: 0 clean, 1 repaired, 2 uncorrectable}
  localparam logic [9:0] MASK_TAB [N_MASK] = '{
    {8'h00, 2'd0}, {8'h01, 2'd1}, {8'h02, 2'd1}, {8'h04, 2'd1},
    {8'h08, 2'd1}, {8'h10, 2'd1}, {8'h20, 2'd1}, {8'h40, 2'd1},
    {8'h80, 2'd1}, {8'h03, 2'd2}, {8'h50, 2'd2}, {8'h81, 2'd2}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] encData;
  logic [7:0] encWord;
  logic       inValid;
  logic [7:0] inWord;
  logic       outValid;
  logic [7:0] outWord;
  logic [3:0] outData;
  logic       outClean, outCorrected, outUncorr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_corrector u_dut (
    .clk(clk), .rstN(rstN), .encData(encData), .encWord(encWord),
    .inValid(inValid), .inWord(inWord), .outValid(outValid), .outWord(outWord),
    .outData(outData), .outClean(outClean), .outCorrected(outCorrected),
    .outUncorr(outUncorr)
  );

  function automatic logic [7:0] refEncode(input logic [3:0] d);
    logic [6:0] b;
    b = {d[3]^d[2]^d[1], d[3]^d[2]^d[0], d[3]^d[1]^d[0], d};
    return {^b, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] lastWord;
    rstN = 1'b0; inValid = 1'b0; inWord = '0; encData = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({outValid, outWord, outClean, outCorrected, outUncorr} == '0, "R9 reset",
        {outValid, outWord, outClean, outCorrected, outUncorr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    lastWord = '0;
    for (int d = 0; d < 16; d++) begin
      for (int t = 0; t < N_MASK; t++) begin
        logic [7:0] good, mask, expWord;
        logic [1:0] cls;
        string tag;
        good = refEncode(4'(d));
        mask = MASK_TAB[t][9:2];
        cls  = MASK_TAB[t][1:0];
        if (cls == 2'd0) tag = "R3 clean";
        else if (cls == 2'd2) tag = "R7 double";
        else if (mask[7]) tag = "R6 overall bit";
        else if (mask[6:4] != 0) tag = "R5 check bit";
        else tag = "R4 data bit";
        expWord = (cls == 2'd2) ? (good ^ mask) : good;
        encData = 4'(d);
        inWord  = good ^ mask;
        inValid = 1'b1;
        if (t == 0) begin
          #1;
          chk(encWord[6:0] == good[6:0], "R1 encode", encWord, good);
          chk(^encWord == 1'b0, "R2 overall parity", encWord, good);
        end
        @(negedge clk);
        chk(outValid == 1'b1, {tag, " valid R8"}, outValid, 1);
        chk(outWord == expWord, {tag, " word"}, outWord, expWord);
        chk(outData == expWord[3:0], {tag, " data"}, outData, expWord[3:0]);
        chk({outClean, outCorrected, outUncorr} == {cls == 2'd0, cls == 2'd1, cls == 2'd2},
            {tag, " flags"}, {outClean, outCorrected, outUncorr},
            {cls == 2'd0, cls == 2'd1, cls == 2'd2});
        lastWord = expWord;
      end
    end

    // R8 hold while idle
    inValid = 1'b0;
    inWord  = 8'hFF;
    @(negedge clk);
    chk(outValid == 1'b0, "R8 idle valid", outValid, 0);
    chk(outWord == lastWord, "R8 idle hold word", outWord, lastWord);
    chk(outUncorr == 1'b1, "R8 idle hold flag", outUncorr, 1);

    // R9 reset mid-run
    inValid = 1'b1;
    inWord  = refEncode(4'hA);
    rstN = 1'b0;
    @(negedge clk);
    chk({outValid, outWord, outClean, outCorrected, outUncorr} == '0, "R9 reset mid-run",
        {outValid, outWord, outClean, outCorrected, outUncorr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outClean && outData == 4'hA, "R3 after reset", {outClean, outData}, {1'b1, 4'hA});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule